// File: doc/BRIEF.md
# Start-Up Configuration and Soft-Start Sequencer

This block brings a buck converter's digital controller from idle to regulation once a start request arrives. The request is the enable input together with a valid regulator-supply flag. A start opens a fixed-length calibration window in which the power stage must not switch. The window ends with a one-time capture of a 3-bit switching-frequency selection and a 2-bit soft-start selection.

After calibration, switching is allowed and a digital reference code climbs linearly from zero to full scale. The climb takes one of four durations, each twice the one before. The frequency preset in kHz is presented beside the captured code. While the ramp runs and afterwards, a registered copy of the mode flag picks forced-continuous operation (flag high) or auto-skip (flag low). A done flag marks the end of the ramp. Dropping the request at any point returns everything to idle.

Top module: `startup_seq`

## Requirements
- R1: A start request is `en_i & vreg_ok_i`. Out of reset all outputs except `freq_khz_o` are zero. The first clock edge that sees the request high enters calibration.
- R2: Calibration lasts CAL_CYCLES clock cycles, counted from the edge that entered it. Throughout calibration `sw_en_o` is 0 and `ref_o` is 0. `sw_en_o` rises at the edge that ends calibration.
- R3: `freq_sel_o` and `ss_sel_o` take the values of `freq_code_i` and `ss_code_i` present at the edge that ends calibration. They hold those values until the request drops, whatever the inputs do later. They read 0 before capture.
- R4: `freq_khz_o` maps `freq_sel_o` codes 0..7 to 250, 300, 400, 500, 650, 750, 850 and 970.
- R5: From the edge that ends calibration, `ref_o` rises by exactly one every STEP_BASE<<`ss_sel_o` cycles, where STEP_BASE = SS_BASE_CYCLES/(2^REF_W-1). It reaches full scale 2^REF_W-1 after (2^REF_W-1)*(STEP_BASE<<`ss_sel_o`) cycles, then holds and never exceeds it.
- R6: `fccm_o` is `mode_i` registered by one clock, but only at edges taken while the ramp or done phase is active; at all other times it is 0.
- R7: `ss_done_o` rises one clock after `ref_o` reaches full scale and stays high while the request is held.
- R8: If the request is low at a clock edge, then after that edge `ref_o`, `sw_en_o`, `ss_done_o`, `fccm_o`, `freq_sel_o` and `ss_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable request |
| vreg_ok_i | input | 1 | Regulator supply valid |
| freq_code_i | input | 3 | Switching-frequency selection code |
| ss_code_i | input | 2 | Soft-start duration selection code |
| mode_i | input | 1 | Mode comparator flag (1 = forced continuous) |
| ref_o | output | REF_W | Reference code |
| sw_en_o | output | 1 | Switching allowed |
| freq_sel_o | output | 3 | Captured frequency code |
| freq_khz_o | output | 10 | Frequency preset in kHz |
| ss_sel_o | output | 2 | Captured soft-start code |
| fccm_o | output | 1 | Forced-continuous select |
| ss_done_o | output | 1 | Soft-start complete |

## Verification
The bench sweeps all 32 combinations of the frequency and soft-start codes. In each run it predicts every output cycle by cycle from the edge count since the request rose. An off-by-one in the calibration counter would move the `sw_en_o` edge by one cycle. A step divider that lost or gained a cycle would drift the ramp, and the drift would be largest at the slowest preset. The bench scrambles both selection inputs right after capture, so a design that kept re-reading them would change its ramp rate and output codes. It also drops enable and the supply flag in mid-ramp and after done, and checks that the mode register and the ramp leave no one-cycle residue.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_RAMP = 2'd2,
    ST_DONE = 2'd3
  } ssq_state_e;

  function automatic logic [9:0] preset_khz(input logic [2:0] code);
    case (code)
      3'd0:    return 10'd250;
      3'd1:    return 10'd300;
      3'd2:    return 10'd400;
      3'd3:    return 10'd500;
      3'd4:    return 10'd650;
      3'd5:    return 10'd750;
      3'd6:    return 10'd850;
      default: return 10'd970;
    endcase
  endfunction
endpackage

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int CAL_CYCLES = 25000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       at_full_i,
  input  logic [2:0] freq_code_i,
  input  logic [1:0] ss_code_i,
  output ssq_state_e state_o,
  output logic [2:0] freq_sel_o,
  output logic [1:0] ss_sel_o
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] CAL_LAST = CW'(CAL_CYCLES - 1);

  ssq_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic [2:0]      fsel_q;
  logic [1:0]      ssel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fsel_q  <= '0;
      ssel_q  <= '0;
    end else if (!go_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fsel_q  <= '0;
      ssel_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q <= ST_CAL;
          cnt_q   <= '0;
        end
        ST_CAL: begin
          if (cnt_q == CAL_LAST) begin
            state_q <= ST_RAMP;
            fsel_q  <= freq_code_i;   // one-time capture
            ssel_q  <= ss_code_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RAMP: if (at_full_i) state_q <= ST_DONE;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign freq_sel_o = fsel_q;
  assign ss_sel_o   = ssel_q;
endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
  parameter int REF_W     = 10,
  parameter int STEP_BASE = 68
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             run_i,
  input  logic [1:0]       ss_sel_i,
  output logic [REF_W-1:0] ref_o,
  output logic             at_full_o
);
  localparam int PW = $clog2(STEP_BASE * 8 + 1);
  localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};

  logic [PW-1:0]    pre_q;
  logic [PW-1:0]    step_last;
  logic [REF_W-1:0] ref_q;

  // doubling presets: period = STEP_BASE << sel
  assign step_last = (PW'(STEP_BASE) << ss_sel_i) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ref_q <= '0;
    end else if (!hold_i) begin
      pre_q <= '0;
      ref_q <= '0;
    end else if (run_i && ref_q != FULL) begin
      if (pre_q == step_last) begin
        pre_q <= '0;
        ref_q <= ref_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign ref_o     = ref_q;
  assign at_full_o = (ref_q == FULL);
endmodule

// File: rtl/ssq_mode.sv
module ssq_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic mode_i,
  output logic fccm_o
);
  logic fccm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fccm_q <= 1'b0;
    else if (active_i) fccm_q <= mode_i;
    else               fccm_q <= 1'b0;
  end

  assign fccm_o = fccm_q;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import ssq_pkg::*;
#(
  parameter int CAL_CYCLES     = 25000,
  parameter int REF_W          = 10,
  parameter int SS_BASE_CYCLES = 70000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vreg_ok_i,
  input  logic [2:0]       freq_code_i,
  input  logic [1:0]       ss_code_i,
  input  logic             mode_i,
  output logic [REF_W-1:0] ref_o,
  output logic             sw_en_o,
  output logic [2:0]       freq_sel_o,
  output logic [9:0]       freq_khz_o,
  output logic [1:0]       ss_sel_o,
  output logic             fccm_o,
  output logic             ss_done_o
);
  localparam int FULL_CNT  = (1 << REF_W) - 1;
  localparam int STEP_RAW  = SS_BASE_CYCLES / FULL_CNT;
  localparam int STEP_BASE = (STEP_RAW < 1) ? 1 : STEP_RAW;

  ssq_state_e state;
  logic       go, active, at_full;

  assign go     = en_i & vreg_ok_i;
  assign active = go & ((state == ST_RAMP) | (state == ST_DONE));

  ssq_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .at_full_i   (at_full),
    .freq_code_i (freq_code_i),
    .ss_code_i   (ss_code_i),
    .state_o     (state),
    .freq_sel_o  (freq_sel_o),
    .ss_sel_o    (ss_sel_o)
  );

  ssq_ramp #(.REF_W(REF_W), .STEP_BASE(STEP_BASE)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (active),
    .run_i     (state == ST_RAMP),
    .ss_sel_i  (ss_sel_o),
    .ref_o     (ref_o),
    .at_full_o (at_full)
  );

  ssq_mode u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .mode_i   (mode_i),
    .fccm_o   (fccm_o)
  );

  assign sw_en_o    = (state == ST_RAMP) | (state == ST_DONE);
  assign ss_done_o  = (state == ST_DONE);
  assign freq_khz_o = preset_khz(freq_sel_o);
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
  parameter int REF_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             vreg_ok_i,
  input logic [REF_W-1:0] ref_o,
  input logic             sw_en_o,
  input logic [2:0]       freq_sel_o,
  input logic [1:0]       ss_sel_o,
  input logic             fccm_o,
  input logic             ss_done_o
);
  logic go;
  assign go = en_i & vreg_ok_i;

  a_r2_ref_zero_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> ref_o == '0);

  a_r3_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && $past(sw_en_o)) |-> ($stable(freq_sel_o) && $stable(ss_sel_o)));

  a_r5_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && $past(sw_en_o)) |->
      ((ref_o == $past(ref_o)) || ({1'b0, ref_o} == {1'b0, $past(ref_o)} + 1'b1)));

  a_r6_mode_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> !fccm_o);

  a_r7_done_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_done_o |-> ref_o == {REF_W{1'b1}});

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_done_o && go) |=> ss_done_o);

  a_r8_drop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> (ref_o == '0 && !sw_en_o && !ss_done_o && !fccm_o
             && freq_sel_o == '0 && ss_sel_o == '0));
endmodule

bind startup_seq startup_seq_chk #(.REF_W(REF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .vreg_ok_i  (vreg_ok_i),
  .ref_o      (ref_o),
  .sw_en_o    (sw_en_o),
  .freq_sel_o (freq_sel_o),
  .ss_sel_o   (ss_sel_o),
  .fccm_o     (fccm_o),
  .ss_done_o  (ss_done_o)
);

// File: tb/sim_startup_seq.sv
`timescale 1ns/1ps
module sim_startup_seq;
  localparam int CAL   = 10;
  localparam int REF_W = 4;
  localparam int SSB   = 30;
  localparam int FULL  = (1 << REF_W) - 1;
  localparam int STEPB = SSB / FULL;   // 2

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, vok = 1'b0, mode = 1'b0;
  logic [2:0] fcode = '0;
  logic [1:0] scode = '0;
  logic [REF_W-1:0] ref_v;
  logic sw_en, fccm, done;
  logic [2:0] fsel;
  logic [9:0] khz;
  logic [1:0] ssel;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  startup_seq #(.CAL_CYCLES(CAL), .REF_W(REF_W), .SS_BASE_CYCLES(SSB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vreg_ok_i(vok),
    .freq_code_i(fcode), .ss_code_i(scode), .mode_i(mode),
    .ref_o(ref_v), .sw_en_o(sw_en), .freq_sel_o(fsel), .freq_khz_o(khz),
    .ss_sel_o(ssel), .fccm_o(fccm), .ss_done_o(done)
  );

  function automatic int khz_of(input int c);
    case (c)
      0: return 250; 1: return 300; 2: return 400; 3: return 500;
      4: return 650; 5: return 750; 6: return 850; default: return 970;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " ref"}, int'(ref_v), 0);
    chk({tag, " sw_en"}, int'(sw_en), 0);
    chk({tag, " done"}, int'(done), 0);
    chk({tag, " fccm"}, int'(fccm), 0);
    chk({tag, " fsel"}, int'(fsel), 0);
    chk({tag, " ssel"}, int'(ssel), 0);
  endtask

  // Full start-up; abort_m >= 0 drops the request m cycles into the ramp.
  task automatic run(input int f, input int s, input int abort_m, input bit by_vreg);
    int step, last_m, mprev;
    step   = STEPB << s;
    last_m = (abort_m >= 0) ? abort_m : FULL * step + 4;
    @(negedge clk);
    fcode = 3'(f); scode = 2'(s); mode = 1'b0; mprev = 0;
    en = 1'b1; vok = 1'b1;
    for (int n = 1; ; n++) begin
      int m;
      @(posedge clk); @(negedge clk);
      m = n - (CAL + 1);
      if (m < 0) begin
        chk("R2 sw_en in cal", int'(sw_en), 0);
        chk("R2 ref in cal", int'(ref_v), 0);
        chk("R3 codes before capture", int'({fsel, ssel}), 0);
        chk("R6 fccm in cal", int'(fccm), 0);
      end else begin
        int eref;
        eref = m / step;
        if (eref > FULL) eref = FULL;
        chk("R2 sw_en after cal", int'(sw_en), 1);
        chk("R5 ref ramp", int'(ref_v), eref);
        chk("R3 freq code held", int'(fsel), f);
        chk("R3 ss code held", int'(ssel), s);
        chk("R4 khz preset", int'(khz), khz_of(f));
        chk("R7 done timing", int'(done), (m >= FULL * step + 1) ? 1 : 0);
        chk("R6 fccm", int'(fccm), (m >= 1) ? mprev : 0);
        fcode = ~3'(f); scode = ~2'(s);   // must not be re-read
      end
      mprev = ((n / 3) + f) % 2;
      mode  = mprev[0];
      if (m >= last_m) break;
    end
    if (by_vreg) vok = 1'b0; else en = 1'b0;
    @(posedge clk); @(negedge clk);
    check_idle(by_vreg ? "R8 vreg drop" : "R8 enable drop");
    en = 1'b0; vok = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    chk("R1 khz at reset", int'(khz), 250);
    rst_n = 1'b1;
    // supply invalid: enable alone must not start (R1)
    en = 1'b1; vok = 1'b0;
    repeat (CAL + 4) @(negedge clk);
    check_idle("R1 no start without vreg");
    en = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 8; f++)
        run(f, s, -1, 1'b0);
    run(5, 3, 20, 1'b0);   // abort mid-ramp
    run(2, 1, 0, 1'b1);    // abort at ramp entry by supply
    run(7, 2, 40, 1'b1);
    run(1, 0, -1, 1'b1);   // drop after done
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule